// File: doc/BRIEF.md
# USB Endpoint Mode Handshake Controller

This block keeps the 4-bit operating mode of one USB endpoint and a separate stall flag. Each time the serial engine reports a token (SETUP, IN or OUT), the block picks the endpoint's answer: ignore it, accept it, ACK, NAK, STALL, send a zero-length data packet, or send a data packet whose length is the programmed transmit count. The answer is registered and appears one clock after the token strobe.

When the serial engine reports that a transaction finished with an ACK handshake, the block moves the mode to a follow-on state by itself. For example, a one-shot "ACK OUT" mode falls back to "NAK OUT", so firmware must re-arm the endpoint before it takes more data. Firmware loads the mode and the stall flag through a one-cycle write port. A flag from the serial engine says whether the endpoint is a control endpoint. That flag decides whether SETUP tokens are accepted and whether the stall flag has any effect.

Top module: `usb_ep_mode_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `ep_mode` is 4'b0000, `ep_stall` is 0 and `rsp_valid` is 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `tok_valid` high. The answer is decided from the mode, stall flag, `ep_is_ctrl` and `tx_count` present in the token cycle. Token kind codes are 0 = SETUP, 1 = IN, 2 = OUT and 3 = none. Kind 3 is answered with IGNORE.
- R3: Modes 4'b0000, 4'b0101 and 4'b0111 answer IGNORE (code 0) to every token kind.
- R4: A SETUP is answered ACCEPT (code 1) only when `ep_is_ctrl` is 1 and the mode is one of 0001, 0010, 0011, 0100, 0110, 1010, 1011, 1110 or 1111. Every other case answers IGNORE.
- R5: IN answers are as follows. NAK (3) in modes 0001, 1011, 1100 and 1110. STALL (4) in 0010 and 0011. Zero-length data (5) in 0110 and 1010. Counted data (6) in 1101 and 1111. IGNORE in all other modes.
- R6: OUT answers are as follows. NAK (3) in modes 0001, 1000 and 1010. ACK (2) in 0010, 1001, 1011, 1110 and 1111. STALL (4) in 0011 and 0110. IGNORE in all other modes.
- R7: `ack_done` following a SETUP sets the mode to 0001 when `ep_is_ctrl` is 1 and the mode is not 0000. Otherwise the mode is unchanged.
- R8: `ack_done` following an OUT moves mode 1011 to 0001 and mode 1001 to 1000. Every other mode is unchanged.
- R9: `ack_done` following an IN moves mode 1101 to 1100 and mode 1111 to 1110. Every other mode is unchanged.
- R10: When `ep_is_ctrl` is 0 and the stall flag is 1, every answer other than IGNORE becomes STALL (4). When `ep_is_ctrl` is 1, the stall flag has no effect on the answer.
- R11: When `fw_we` is high, the next mode and stall flag are `fw_mode` and `fw_stall`, even if `ack_done` would step the mode in the same cycle.
- R12: `rsp_len` equals the token-cycle `tx_count` for counted data (6). It is 0 for every other answer, including zero-length data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_we | input | 1 | Firmware write strobe for mode and stall flag |
| fw_mode | input | 4 | Mode value to load |
| fw_stall | input | 1 | Stall flag value to load |
| ep_is_ctrl | input | 1 | 1 = control endpoint |
| tx_count | input | CNT_W | Programmed transmit byte count |
| tok_valid | input | 1 | Token strobe from the serial engine |
| tok_kind | input | 2 | Token kind: 0 SETUP, 1 IN, 2 OUT, 3 none |
| ack_done | input | 1 | Last transaction completed with an ACK handshake |
| rsp_valid | output | 1 | Answer valid strobe |
| rsp_code | output | 3 | 0 IGNORE, 1 ACCEPT, 2 ACK, 3 NAK, 4 STALL, 5 zero-length data, 6 counted data |
| rsp_len | output | CNT_W | Data length for the answer |
| ep_mode | output | 4 | Current mode |
| ep_stall | output | 1 | Current stall flag |

## Verification
The hardest situations to reach are the ones where several inputs meet in one clock edge. These are a firmware write in the same cycle as an `ack_done` that would step the mode, a token arriving in the same cycle as an `ack_done` for the previous token, and the stall flag meeting each mode on a non-control endpoint. A directed sweep covers every mode with every token kind, both endpoint types and both stall values, each with and without a following ACK. A directed collision case sets up a one-shot mode and then writes it during the ACK. A long random phase then drives all inputs independently every cycle, so that tokens, ACKs and writes overlap in all combinations. Throughout, a behavioural model tracks the last token kind itself and is compared with the outputs on every clock.

// File: rtl/usb_epm_pkg.sv
// Package: shared types and mode constants for the endpoint mode controller.
// Assumes a 4-bit mode encoding whose values are fixed by the handshake rules.
package usb_epm_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_IN    = 2'd1,
        TOK_OUT   = 2'd2,
        TOK_NONE  = 2'd3
    } tok_kind_e;

    typedef enum logic [2:0] {
        RSP_IGNORE  = 3'd0,
        RSP_ACCEPT  = 3'd1,
        RSP_ACK     = 3'd2,
        RSP_NAK     = 3'd3,
        RSP_STALL   = 3'd4,
        RSP_TX_ZERO = 3'd5,
        RSP_TX_DATA = 3'd6
    } rsp_e;

    // Answer plan of one mode for each token kind.
    typedef struct packed {
        rsp_e setup_rsp;
        rsp_e in_rsp;
        rsp_e out_rsp;
    } mode_plan_t;

    localparam logic [MODE_W-1:0] M_OFF          = 4'b0000;
    localparam logic [MODE_W-1:0] M_NAK_BOTH     = 4'b0001;
    localparam logic [MODE_W-1:0] M_STAT_OUT     = 4'b0010;
    localparam logic [MODE_W-1:0] M_STALL_BOTH   = 4'b0011;
    localparam logic [MODE_W-1:0] M_QUIET_BOTH   = 4'b0100;
    localparam logic [MODE_W-1:0] M_RSVD_A       = 4'b0101;
    localparam logic [MODE_W-1:0] M_STAT_IN      = 4'b0110;
    localparam logic [MODE_W-1:0] M_RSVD_B       = 4'b0111;
    localparam logic [MODE_W-1:0] M_NAK_OUT      = 4'b1000;
    localparam logic [MODE_W-1:0] M_ACK_OUT      = 4'b1001;
    localparam logic [MODE_W-1:0] M_NAKO_STATI   = 4'b1010;
    localparam logic [MODE_W-1:0] M_ACKO_NAKI    = 4'b1011;
    localparam logic [MODE_W-1:0] M_NAK_IN       = 4'b1100;
    localparam logic [MODE_W-1:0] M_ACK_IN       = 4'b1101;
    localparam logic [MODE_W-1:0] M_NAKI_STATO   = 4'b1110;
    localparam logic [MODE_W-1:0] M_ACKI_STATO   = 4'b1111;

endpackage

// File: rtl/epm_mode_table.sv
// Module: combinational decode of a mode into its answer plan.
// Assumes SETUP is only meaningful on control endpoints; reserved modes stay silent.
module epm_mode_table
    import usb_epm_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              is_ctrl,
    output mode_plan_t        plan
);

    mode_plan_t raw_plan;

    // Map each mode to its SETUP/IN/OUT answers.
    always_comb begin
        raw_plan = '{setup_rsp: RSP_IGNORE, in_rsp: RSP_IGNORE, out_rsp: RSP_IGNORE};
        unique case (mode)
            M_NAK_BOTH:   raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_NAK,     out_rsp: RSP_NAK};
            M_STAT_OUT:   raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_STALL,   out_rsp: RSP_ACK};
            M_STALL_BOTH: raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_STALL,   out_rsp: RSP_STALL};
            M_QUIET_BOTH: raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_IGNORE,  out_rsp: RSP_IGNORE};
            M_STAT_IN:    raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_TX_ZERO, out_rsp: RSP_STALL};
            M_NAK_OUT:    raw_plan = '{setup_rsp: RSP_IGNORE, in_rsp: RSP_IGNORE,  out_rsp: RSP_NAK};
            M_ACK_OUT:    raw_plan = '{setup_rsp: RSP_IGNORE, in_rsp: RSP_IGNORE,  out_rsp: RSP_ACK};
            M_NAKO_STATI: raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_TX_ZERO, out_rsp: RSP_NAK};
            M_ACKO_NAKI:  raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_NAK,     out_rsp: RSP_ACK};
            M_NAK_IN:     raw_plan = '{setup_rsp: RSP_IGNORE, in_rsp: RSP_NAK,     out_rsp: RSP_IGNORE};
            M_ACK_IN:     raw_plan = '{setup_rsp: RSP_IGNORE, in_rsp: RSP_TX_DATA, out_rsp: RSP_IGNORE};
            M_NAKI_STATO: raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_NAK,     out_rsp: RSP_ACK};
            M_ACKI_STATO: raw_plan = '{setup_rsp: RSP_ACCEPT, in_rsp: RSP_TX_DATA, out_rsp: RSP_ACK};
            default:      raw_plan = '{setup_rsp: RSP_IGNORE, in_rsp: RSP_IGNORE,  out_rsp: RSP_IGNORE};
        endcase
    end

    // Non-control endpoints never take SETUP.
    always_comb begin
        plan = raw_plan;
        if (!is_ctrl) plan.setup_rsp = RSP_IGNORE;
    end

endmodule

// File: rtl/epm_mode_reg.sv
// Module: mode and stall-flag register with the automatic step after an ACK.
// Assumes ack_done refers to the most recent token seen before that cycle;
// a firmware write wins over an automatic step in the same cycle.
module epm_mode_reg
    import usb_epm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fw_we,
    input  logic [MODE_W-1:0] fw_mode,
    input  logic              fw_stall,
    input  logic              tok_valid,
    input  tok_kind_e         tok_kind,
    input  logic              ack_done,
    input  logic              is_ctrl,
    output logic [MODE_W-1:0] mode_q,
    output logic              stall_q
);

    tok_kind_e         last_kind_q;
    logic [MODE_W-1:0] step_mode;
    logic              step_hit;

    // Work out the follow-on mode for an ACK of the last token.
    always_comb begin
        step_mode = mode_q;
        step_hit  = 1'b0;
        if (ack_done) begin
            unique case (last_kind_q)
                TOK_SETUP: begin
                    if (is_ctrl && (mode_q != M_OFF)) begin
                        step_mode = M_NAK_BOTH;
                        step_hit  = 1'b1;
                    end
                end
                TOK_OUT: begin
                    if (mode_q == M_ACKO_NAKI) begin
                        step_mode = M_NAK_BOTH;
                        step_hit  = 1'b1;
                    end else if (mode_q == M_ACK_OUT) begin
                        step_mode = M_NAK_OUT;
                        step_hit  = 1'b1;
                    end
                end
                TOK_IN: begin
                    if (mode_q == M_ACK_IN) begin
                        step_mode = M_NAK_IN;
                        step_hit  = 1'b1;
                    end else if (mode_q == M_ACKI_STATO) begin
                        step_mode = M_NAKI_STATO;
                        step_hit  = 1'b1;
                    end
                end
                default: begin
                    step_mode = mode_q;
                    step_hit  = 1'b0;
                end
            endcase
        end
    end

    // Load from firmware first, otherwise apply the automatic step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_OFF;
            stall_q <= 1'b0;
        end else if (fw_we) begin
            mode_q  <= fw_mode;
            stall_q <= fw_stall;
        end else if (step_hit) begin
            mode_q  <= step_mode;
        end
    end

    // Remember which token kind an upcoming ACK belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_kind_q <= TOK_NONE;
        else if (tok_valid) last_kind_q <= tok_kind;
    end

    AST_SETUP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && !fw_we && is_ctrl && last_kind_q == TOK_SETUP && mode_q != M_OFF)
        |=> (mode_q == M_NAK_BOTH)); // R7
    AST_OUT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && !fw_we && last_kind_q == TOK_OUT && mode_q == M_ACK_OUT)
        |=> (mode_q == M_NAK_OUT)); // R8
    AST_IN_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && !fw_we && last_kind_q == TOK_IN && mode_q == M_ACKI_STATO)
        |=> (mode_q == M_NAKI_STATO)); // R9
    AST_FW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fw_we |=> (mode_q == $past(fw_mode) && stall_q == $past(fw_stall))); // R11

endmodule

// File: rtl/epm_resp_stage.sv
// Module: picks the answer for the current token, applies the stall override
// and registers the result. Assumes the plan reflects the mode in the token cycle.
module epm_resp_stage
    import usb_epm_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_plan_t       plan,
    input  logic             tok_valid,
    input  tok_kind_e        tok_kind,
    input  logic             stall_bit,
    input  logic             is_ctrl,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rsp_valid_q,
    output rsp_e             rsp_code_q,
    output logic [CNT_W-1:0] rsp_len_q
);

    rsp_e picked;
    rsp_e final_rsp;

    // Select the plan entry for this token kind.
    always_comb begin
        unique case (tok_kind)
            TOK_SETUP: picked = plan.setup_rsp;
            TOK_IN:    picked = plan.in_rsp;
            TOK_OUT:   picked = plan.out_rsp;
            default:   picked = RSP_IGNORE;
        endcase
    end

    // On non-control endpoints the stall flag replaces any non-silent answer.
    always_comb begin
        final_rsp = picked;
        if (!is_ctrl && stall_bit && (picked != RSP_IGNORE)) final_rsp = RSP_STALL;
    end

    // Register the answer so it appears one cycle after the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_code_q  <= RSP_IGNORE;
            rsp_len_q   <= '0;
        end else begin
            rsp_valid_q <= tok_valid;
            rsp_code_q  <= tok_valid ? final_rsp : RSP_IGNORE;
            rsp_len_q   <= (tok_valid && final_rsp == RSP_TX_DATA) ? tx_count : '0;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> rsp_valid_q); // R2
    AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !rsp_valid_q); // R2
    AST_STALL_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !is_ctrl && stall_bit && picked != RSP_IGNORE)
        |=> (rsp_code_q == RSP_STALL)); // R10
    AST_LEN_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_q && rsp_code_q != RSP_TX_DATA) |-> (rsp_len_q == '0)); // R12

endmodule

// File: rtl/usb_ep_mode_ctrl.sv
// Module: top of the endpoint mode handshake controller. Connects the mode
// register, the mode decode and the registered answer stage.
// Assumes one token strobe per transaction and ack_done only after its token.
module usb_ep_mode_ctrl
    import usb_epm_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fw_we,
    input  logic [3:0]       fw_mode,
    input  logic             fw_stall,
    input  logic             ep_is_ctrl,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             ack_done,
    output logic             rsp_valid,
    output logic [2:0]       rsp_code,
    output logic [CNT_W-1:0] rsp_len,
    output logic [3:0]       ep_mode,
    output logic             ep_stall
);

    tok_kind_e         kind_e;
    mode_plan_t        plan;
    rsp_e              code_e;
    logic [MODE_W-1:0] mode_w;
    logic              stall_w;

    assign kind_e = tok_kind_e'(tok_kind);

    epm_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .fw_we     (fw_we),
        .fw_mode   (fw_mode),
        .fw_stall  (fw_stall),
        .tok_valid (tok_valid),
        .tok_kind  (kind_e),
        .ack_done  (ack_done),
        .is_ctrl   (ep_is_ctrl),
        .mode_q    (mode_w),
        .stall_q   (stall_w)
    );

    epm_mode_table u_table (
        .mode    (mode_w),
        .is_ctrl (ep_is_ctrl),
        .plan    (plan)
    );

    epm_resp_stage #(.CNT_W(CNT_W)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .plan        (plan),
        .tok_valid   (tok_valid),
        .tok_kind    (kind_e),
        .stall_bit   (stall_w),
        .is_ctrl     (ep_is_ctrl),
        .tx_count    (tx_count),
        .rsp_valid_q (rsp_valid),
        .rsp_code_q  (code_e),
        .rsp_len_q   (rsp_len)
    );

    assign rsp_code = code_e;
    assign ep_mode  = mode_w;
    assign ep_stall = stall_w;

    AST_SILENT_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && (mode_w == M_OFF || mode_w == M_RSVD_A || mode_w == M_RSVD_B))
        |=> (rsp_code == 3'd0)); // R3
    AST_SETUP_NONCTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && kind_e == TOK_SETUP && !ep_is_ctrl)
        |=> (rsp_code == 3'd0)); // R4

endmodule

// File: tb/tb_usb_ep_mode_ctrl.sv
module tb_usb_ep_mode_ctrl;

    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fw_we = 1'b0;
    logic [3:0]       fw_mode = '0;
    logic             fw_stall = 1'b0;
    logic             ep_is_ctrl = 1'b0;
    logic [CNT_W-1:0] tx_count = '0;
    logic             tok_valid = 1'b0;
    logic [1:0]       tok_kind = 2'd3;
    logic             ack_done = 1'b0;
    logic             rsp_valid;
    logic [2:0]       rsp_code;
    logic [CNT_W-1:0] rsp_len;
    logic [3:0]       ep_mode;
    logic             ep_stall;

    usb_ep_mode_ctrl #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .fw_we(fw_we), .fw_mode(fw_mode),
        .fw_stall(fw_stall), .ep_is_ctrl(ep_is_ctrl), .tx_count(tx_count),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .ack_done(ack_done),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
        .ep_mode(ep_mode), .ep_stall(ep_stall)
    );

    always #10 clk = ~clk; // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    int    m_mode = 0, m_stall = 0, m_last = 3;
    int    m_rv = 0, m_code = 0, m_len = 0;
    string m_rtag = "R2";
    string m_mtag = "R1";

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int in_set(int v, int q[$]);
        foreach (q[i]) if (q[i] == v) return 1;
        return 0;
    endfunction

    // Expected answer from the requirement tables.
    function automatic int exp_answer(int mode, int kind, int ctrl, int stl);
        int r;
        r = 0;
        if (kind == 0)
            r = (ctrl != 0 && in_set(mode, '{1, 2, 3, 4, 6, 10, 11, 14, 15})) ? 1 : 0;
        else if (kind == 1) begin
            if (in_set(mode, '{1, 11, 12, 14})) r = 3;
            else if (in_set(mode, '{2, 3}))    r = 4;
            else if (in_set(mode, '{6, 10}))   r = 5;
            else if (in_set(mode, '{13, 15}))  r = 6;
        end else if (kind == 2) begin
            if (in_set(mode, '{1, 8, 10}))             r = 3;
            else if (in_set(mode, '{2, 9, 11, 14, 15})) r = 2;
            else if (in_set(mode, '{3, 6}))             r = 4;
        end
        if (ctrl == 0 && stl != 0 && r != 0) r = 4;
        return r;
    endfunction

    // Model: evaluate at each rising edge from the inputs held since the last falling edge.
    always @(posedge clk) begin
        int nm, ns;
        if (!rst_n) begin
            m_mode = 0; m_stall = 0; m_last = 3;
            m_rv = 0; m_code = 0; m_len = 0;
            m_rtag = "R1"; m_mtag = "R1";
        end else begin
            m_rv = tok_valid;
            if (tok_valid) begin
                m_code = exp_answer(m_mode, tok_kind, ep_is_ctrl, m_stall);
                m_len  = (m_code == 6) ? int'(tx_count) : 0;
                if (m_code == 4 && ep_is_ctrl == 0 && m_stall != 0) m_rtag = "R10";
                else if (m_code == 6)                              m_rtag = "R12";
                else if (in_set(m_mode, '{0, 5, 7}))               m_rtag = "R3";
                else if (tok_kind == 0)                            m_rtag = "R4";
                else if (tok_kind == 1)                            m_rtag = "R5";
                else                                               m_rtag = "R6";
            end else begin
                m_code = 0; m_len = 0; m_rtag = "R2";
            end
            nm = m_mode; ns = m_stall; m_mtag = "R1";
            if (ack_done) begin
                if (m_last == 0) begin
                    m_mtag = "R7";
                    if (ep_is_ctrl && m_mode != 0) nm = 1;
                end else if (m_last == 2) begin
                    m_mtag = "R8";
                    if (m_mode == 11) nm = 1;
                    else if (m_mode == 9) nm = 8;
                end else if (m_last == 1) begin
                    m_mtag = "R9";
                    if (m_mode == 13) nm = 12;
                    else if (m_mode == 15) nm = 14;
                end
            end
            if (fw_we) begin
                nm = fw_mode; ns = fw_stall; m_mtag = "R11";
            end
            if (tok_valid) m_last = tok_kind;
            m_mode = nm; m_stall = ns;
        end
    end

    // Compare every cycle at the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            chk("R2", "rsp_valid", rsp_valid, m_rv);
            chk(m_rtag, "rsp_code", rsp_code, m_code);
            chk(m_rtag == "R12" ? "R12" : m_rtag, "rsp_len", rsp_len, m_len);
            chk(m_mtag, "ep_mode", ep_mode, m_mode);
            chk(m_mtag, "ep_stall", ep_stall, m_stall);
        end
    end

    task automatic idle();
        @(negedge clk);
        fw_we = 0; tok_valid = 0; ack_done = 0; tok_kind = 2'd3;
    endtask

    task automatic fw_set(int m, int s);
        @(negedge clk);
        fw_we = 1; fw_mode = 4'(m); fw_stall = s[0];
        tok_valid = 0; ack_done = 0;
        @(negedge clk);
        fw_we = 0;
    endtask

    task automatic token(int k, int cnt, int with_ack);
        @(negedge clk);
        tok_valid = 1; tok_kind = 2'(k); tx_count = CNT_W'(cnt);
        @(negedge clk);
        tok_valid = 0; tok_kind = 2'd3;
        if (with_ack != 0) begin
            ack_done = 1;
            @(negedge clk);
            ack_done = 0;
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset ep_mode", ep_mode, 0);
        chk("R1", "reset ep_stall", ep_stall, 0);
        chk("R1", "reset rsp_valid", rsp_valid, 0);
        rst_n = 1;
        cmp_on = 1;

        // Sweep: every mode x token kind x endpoint type x stall flag, with and without ACK
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int k = 0; k < 4; k++) begin
                        for (int a = 0; a < 2; a++) begin
                            @(negedge clk);
                            ep_is_ctrl = c[0];
                            fw_set(m, s);
                            token(k, (m * 3 + k + 5) % 16, a);
                        end
                    end
                end
            end
        end

        // R11: firmware write collides with an ACK that would step 1001 -> 1000
        ep_is_ctrl = 0;
        fw_set(9, 0);
        token(2, 4, 0);
        @(negedge clk);
        ack_done = 1; fw_we = 1; fw_mode = 4'd3; fw_stall = 1'b0;
        @(negedge clk);
        ack_done = 0; fw_we = 0;
        chk("R11", "collision ep_mode", ep_mode, 3);

        // R8: the same ACK without the write steps the one-shot mode
        fw_set(9, 0);
        token(2, 4, 1);
        chk("R8", "oneshot out ep_mode", ep_mode, 8);

        // R7: SETUP ACK on control endpoint from a data mode
        ep_is_ctrl = 1;
        fw_set(15, 0);
        token(0, 0, 1);
        chk("R7", "setup force ep_mode", ep_mode, 1);

        // R12: counted IN answer carries the count
        fw_set(13, 0);
        @(negedge clk);
        tok_valid = 1; tok_kind = 2'd1; tx_count = CNT_W'(11);
        @(negedge clk);
        tok_valid = 0;
        chk("R12", "tx len", rsp_len, 11);
        chk("R5", "tx code", rsp_code, 6);
        idle();

        // Random phase: every input independent each cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            ep_is_ctrl = ($urandom_range(0, 3) != 0);
            tx_count   = CNT_W'($urandom);
            tok_valid  = ($urandom_range(0, 2) == 0);
            tok_kind   = 2'($urandom);
            ack_done   = ($urandom_range(0, 2) == 0);
            fw_we      = ($urandom_range(0, 5) == 0);
            fw_mode    = 4'($urandom);
            fw_stall   = ($urandom_range(0, 3) == 0);
        end
        idle();
        idle();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule